// File: doc/BRIEF.md
# Sticky-Flag Interrupt Generator

This block collects single-cycle event strobes from nine sources: headset detect, button press, limiter threshold exceeded, noise detect, driver overcurrent, processing overflow, DC measurement ready, SAR data ready and touch detect. Each strobe latches into a sticky flag. A flag stays set until the host reads the register that holds it, and that read clears it. Beside the flags, a live status register shows the present, non-latched level of each event.

Two independent interrupt outputs are built from the flags and strobes. Each output has an enable mask with one bit per event and a mode bit. In one-shot mode, every enabled strobe produces a fixed-length pulse. In train mode, the output toggles with a fixed period for as long as any enabled flag is still set, so the train stops only when the host has read the flags.

Four output pins each have a source selector. A pin can carry either interrupt or be held low. A simple register port with single-cycle read and write strobes gives access to the masks, modes, selectors, flags and live status.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A strobe on event i sets sticky flag bit i at the next clock edge. After reset all flags, masks, modes and pin selectors are zero.
- R2: Flags are read at three addresses: events 0-3 at address 0 bits [3:0], events 4-7 at address 1 bits [3:0], event 8 at address 2 bit 0. A read returns the flags as they were before the read and clears the bits at that address at the clock edge.
- R3: If a strobe arrives in the same cycle as a read that would clear its flag, the flag stays set.
- R4: A read of address 3 returns the live event levels on bits [8:0] in the same cycle, with no latching.
- R5: Address 4 configures interrupt 0 and address 5 configures interrupt 1. Bit 0 is the mode (0 = one-shot, 1 = train) and bits [9:1] enable events 0-8. Both registers read back what was written.
- R6: In one-shot mode, an enabled strobe drives the interrupt high for exactly PULSE_LEN cycles, starting in the cycle after the strobe. A further enabled strobe during the pulse restarts the count. Strobes that are not enabled have no effect.
- R7: In train mode, while any enabled flag is set, the interrupt is high for TRAIN_HI cycles and then low for TRAIN_LO cycles, repeating. The first high phase starts in the first cycle in which an enabled flag is set. The output goes low in the cycle after the last enabled flag is cleared.
- R8: Enabling an event whose flag is already set raises a train-mode interrupt in the cycle after the write. The same write gives no pulse in one-shot mode.
- R9: Addresses 8-11 select the source of pins 0-3 in bits [1:0]. A value of 1 selects interrupt 0 and 2 selects interrupt 1. A value of 0 or 3 drives the pin low.
- R10: Addresses 6, 7 and 12-15 read zero. Writes to flag, status or unused addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_strobe | input | 9 | Single-cycle event pulses |
| evt_level | input | 9 | Present event levels for live status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags at flag addresses) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from address |
| irq_out | output | 2 | The two interrupt outputs |
| pin_out | output | 4 | Steered output pins |

## Verification
The bench aims a strobe at the exact cycle of a read that clears the same flag. A design that gave the read priority would lose that event and leave the flag clear. It retriggers one-shot pulses part-way through and counts their length, which catches a counter that ignores the retrigger or is off by one. It sets flags before enabling them, which separates train mode, which must rise at once, from one-shot mode, which must stay quiet; a design that looked only at strobes, or only at flags, fails one of the two. Random reads at every flag address confirm that a train stops only once every enabled flag has been read, and that pins with selector codes 0 or 3 never follow an interrupt.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

  localparam logic [3:0] ADDR_FLAG0 = 4'd0;
  localparam logic [3:0] ADDR_FLAG1 = 4'd1;
  localparam logic [3:0] ADDR_FLAG2 = 4'd2;
  localparam logic [3:0] ADDR_LIVE  = 4'd3;
  localparam logic [3:0] ADDR_CFG0  = 4'd4;
  localparam logic [3:0] ADDR_CFG1  = 4'd5;
  localparam logic [3:0] ADDR_PIN0  = 4'd8;

  localparam int FLAGS_PER_ADDR = 4;
  localparam int NUM_FLAG_ADDR  = 3;

  typedef enum logic [1:0] {
    PIN_SRC_LOW  = 2'd0,
    PIN_SRC_IRQ0 = 2'd1,
    PIN_SRC_IRQ1 = 2'd2,
    PIN_SRC_OFF  = 2'd3
  } pin_src_e;

  typedef enum logic {
    MODE_ONE_SHOT = 1'b0,
    MODE_TRAIN    = 1'b1
  } irq_mode_e;

  // Bits of the flag vector that a read of addr clears (up to 16 events).
  function automatic logic [15:0] flag_clear_mask(input logic [3:0] addr,
                                                  input logic       rd,
                                                  input int         num_evt);
    logic [15:0] m;
    m = '0;
    for (int i = 0; i < 16; i++) begin
      if (rd && i < num_evt && int'(addr) < NUM_FLAG_ADDR &&
          (i / FLAGS_PER_ADDR) == int'(addr))
        m[i] = 1'b1;
    end
    return m;
  endfunction

  // Train output level for the current phase count.
  function automatic logic train_level(input int cnt, input int hi_len);
    return cnt < hi_len;
  endfunction

  // Next phase count, wrapping at the full period.
  function automatic int train_next(input int cnt, input int period);
    return (cnt >= period - 1) ? 0 : cnt + 1;
  endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_EVT = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic [NUM_EVT-1:0] clr_mask,
  output logic [NUM_EVT-1:0] flag_q
);

  // New events win over a clearing read in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_mask) | evt_strobe;
  end

endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen
  import irq_flag_pkg::*;
#(
  parameter int NUM_EVT   = 9,
  parameter int PULSE_LEN = 4,
  parameter int TRAIN_HI  = 16,
  parameter int TRAIN_LO  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode,
  input  logic [NUM_EVT-1:0] mask,
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic [NUM_EVT-1:0] flag_q,
  output logic               trig,
  output logic               active,
  output logic               irq
);

  localparam int PERIOD = TRAIN_HI + TRAIN_LO;
  localparam int PCW    = $clog2(PULSE_LEN + 1);
  localparam int TCW    = $clog2(PERIOD + 1);

  logic [PCW-1:0] pulse_cnt;
  logic [TCW-1:0] phase_cnt;

  assign trig   = |(evt_strobe & mask);
  assign active = |(flag_q & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pulse_cnt <= '0;
    else if (mode != MODE_ONE_SHOT) pulse_cnt <= '0;
    else if (trig)                 pulse_cnt <= PCW'(PULSE_LEN);
    else if (pulse_cnt != '0)      pulse_cnt <= pulse_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           phase_cnt <= '0;
    else if (mode == MODE_TRAIN && active) phase_cnt <= TCW'(train_next(int'(phase_cnt), PERIOD));
    else                                  phase_cnt <= '0;
  end

  always_comb begin
    if (mode == MODE_ONE_SHOT) irq = (pulse_cnt != '0);
    else                       irq = active && train_level(int'(phase_cnt), TRAIN_HI);
  end

endmodule

// File: rtl/irq_pin_mux.sv
module irq_pin_mux
  import irq_flag_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic [2*NUM_PINS-1:0] pin_sel_flat,
  input  logic [1:0]            irq,
  output logic [NUM_PINS-1:0]   pin_out
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_src_e src;
    assign src = pin_src_e'(pin_sel_flat[2*p +: 2]);
    always_comb begin
      unique case (src)
        PIN_SRC_IRQ0: pin_out[p] = irq[0];
        PIN_SRC_IRQ1: pin_out[p] = irq[1];
        default:      pin_out[p] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int NUM_EVT   = 9,
  parameter int NUM_PINS  = 4,
  parameter int DW        = 16,
  parameter int AW        = 4,
  parameter int PULSE_LEN = 4,
  parameter int TRAIN_HI  = 16,
  parameter int TRAIN_LO  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic [NUM_EVT-1:0] evt_level,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic [1:0]         irq_out,
  output logic [NUM_PINS-1:0] pin_out
);

  localparam int NUM_IRQ = 2;
  localparam int CFG_W   = NUM_EVT + 1;

  logic [NUM_EVT-1:0]     flag_q;
  logic [NUM_EVT-1:0]     clr_mask;
  logic [15:0]            clr_full;
  logic [1:0]             irq_mode;
  logic [NUM_EVT-1:0]     irq_mask [NUM_IRQ];
  logic [2*NUM_EVT-1:0]   irq_mask_flat;
  logic [1:0]             irq_trig;
  logic [1:0]             irq_active;
  logic [2*NUM_PINS-1:0]  pin_sel_flat;
  logic [AW-1:0]          addr_q;

  assign addr_q   = reg_addr;
  assign clr_full = flag_clear_mask(4'(addr_q), reg_rd, NUM_EVT);
  assign clr_mask = clr_full[NUM_EVT-1:0];

  irq_flag_bank #(.NUM_EVT(NUM_EVT)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_strobe (evt_strobe),
    .clr_mask   (clr_mask),
    .flag_q     (flag_q)
  );

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_hit;
    assign cfg_hit = reg_wr && (4'(addr_q) == ADDR_CFG0 + 4'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_q <= '0;
      else if (cfg_hit) cfg_q <= reg_wdata[CFG_W-1:0];
    end

    assign irq_mode[k]                      = cfg_q[0];
    assign irq_mask[k]                      = cfg_q[CFG_W-1:1];
    assign irq_mask_flat[k*NUM_EVT +: NUM_EVT] = cfg_q[CFG_W-1:1];

    irq_pulse_gen #(
      .NUM_EVT   (NUM_EVT),
      .PULSE_LEN (PULSE_LEN),
      .TRAIN_HI  (TRAIN_HI),
      .TRAIN_LO  (TRAIN_LO)
    ) u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (cfg_q[0]),
      .mask       (cfg_q[CFG_W-1:1]),
      .evt_strobe (evt_strobe),
      .flag_q     (flag_q),
      .trig       (irq_trig[k]),
      .active     (irq_active[k]),
      .irq        (irq_out[k])
    );
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_sel
    logic sel_hit;
    assign sel_hit = reg_wr && (4'(addr_q) == ADDR_PIN0 + 4'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pin_sel_flat[2*p +: 2] <= '0;
      else if (sel_hit) pin_sel_flat[2*p +: 2] <= reg_wdata[1:0];
    end
  end

  irq_pin_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .pin_sel_flat (pin_sel_flat),
    .irq          (irq_out),
    .pin_out      (pin_out)
  );

  // Read mux: flags pre-clear, live levels, configuration, pin selectors.
  always_comb begin
    reg_rdata = '0;
    if (int'(addr_q) < NUM_FLAG_ADDR) begin
      for (int i = 0; i < FLAGS_PER_ADDR; i++) begin
        if (int'(addr_q) * FLAGS_PER_ADDR + i < NUM_EVT)
          reg_rdata[i] = flag_q[int'(addr_q) * FLAGS_PER_ADDR + i];
      end
    end else if (4'(addr_q) == ADDR_LIVE) begin
      reg_rdata[NUM_EVT-1:0] = evt_level;
    end else if (4'(addr_q) == ADDR_CFG0) begin
      reg_rdata[CFG_W-1:0] = {irq_mask[0], irq_mode[0]};
    end else if (4'(addr_q) == ADDR_CFG1) begin
      reg_rdata[CFG_W-1:0] = {irq_mask[1], irq_mode[1]};
    end else if (4'(addr_q) >= ADDR_PIN0 && int'(addr_q) < int'(ADDR_PIN0) + NUM_PINS) begin
      reg_rdata[1:0] = pin_sel_flat[2*(int'(addr_q) - int'(ADDR_PIN0)) +: 2];
    end
  end

endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int NUM_EVT  = 9,
  parameter int NUM_PINS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_EVT-1:0]    evt_strobe,
  input logic [NUM_EVT-1:0]    flag_q,
  input logic [NUM_EVT-1:0]    clr_mask,
  input logic [1:0]            irq_mode,
  input logic [2*NUM_EVT-1:0]  irq_mask_flat,
  input logic [1:0]            irq_trig,
  input logic [1:0]            irq_active,
  input logic [1:0]            irq_out,
  input logic [2*NUM_PINS-1:0] pin_sel_flat,
  input logic [NUM_PINS-1:0]   pin_out
);

  assert_event_sets_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_strobe != '0) |=> ((flag_q & $past(evt_strobe)) == $past(evt_strobe)));

  assert_flag_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(flag_q & ~clr_mask)) == $past(flag_q & ~clr_mask)));

  assert_no_spurious_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt_strobe)) == '0));

  assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & flag_q & ~evt_strobe) != '0) |=>
      ((flag_q & $past(clr_mask & flag_q & ~evt_strobe)) == '0));

  assert_event_beats_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_strobe & clr_mask) != '0) |=>
      ((flag_q & $past(evt_strobe & clr_mask)) == $past(evt_strobe & clr_mask)));

  for (genvar k = 0; k < 2; k++) begin : g_irq_chk
    logic [NUM_EVT-1:0] msk;
    assign msk = irq_mask_flat[k*NUM_EVT +: NUM_EVT];

    assert_oneshot_from_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_mode[k] && $past(!irq_mode[k]) && $rose(irq_out[k])) |-> $past(irq_trig[k]));

    assert_train_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mode[k] && ((flag_q & msk) == '0)) |-> !irq_out[k]);

    assert_train_starts_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mode[k] && $past(irq_mode[k]) && irq_active[k] && !$past(irq_active[k]))
        |-> irq_out[k]);
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
    assert_pin_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_sel_flat[2*p +: 2] == 2'd1) |-> (pin_out[p] == irq_out[0]));
    assert_pin_route1_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_sel_flat[2*p +: 2] == 2'd2) |-> (pin_out[p] == irq_out[1]));
    assert_pin_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_sel_flat[2*p +: 2] == 2'd0 || pin_sel_flat[2*p +: 2] == 2'd3) |-> !pin_out[p]);
  end

endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
  .NUM_EVT  (NUM_EVT),
  .NUM_PINS (NUM_PINS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .evt_strobe    (evt_strobe),
  .flag_q        (flag_q),
  .clr_mask      (clr_mask),
  .irq_mode      (irq_mode),
  .irq_mask_flat (irq_mask_flat),
  .irq_trig      (irq_trig),
  .irq_active    (irq_active),
  .irq_out       (irq_out),
  .pin_sel_flat  (pin_sel_flat),
  .pin_out       (pin_out)
);

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NE   = 9;
  localparam int PL   = 4;
  localparam int T_HI = 16;
  localparam int T_LO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  evt_strobe = '0;
  logic [8:0]  evt_level = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  irq_out;
  logic [3:0]  pin_out;

  int checks = 0;
  int errors = 0;
  string dir_tag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_flag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .evt_level(evt_level),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out), .pin_out(pin_out)
  );

  // Reference state, built from the requirements.
  logic [8:0] m_flag;
  logic       m_mode [2];
  logic [8:0] m_mask [2];
  logic [1:0] m_psel [4];
  int         m_pcnt [2];
  int         m_tcnt [2];

  function automatic logic exp_irq(input int k);
    if (m_mode[k]) return (|(m_flag & m_mask[k])) && (m_tcnt[k] < T_HI);
    return m_pcnt[k] != 0;
  endfunction

  function automatic logic exp_pin(input int p);
    if (m_psel[p] == 2'd1) return exp_irq(0);
    if (m_psel[p] == 2'd2) return exp_irq(1);
    return 1'b0;
  endfunction

  function automatic logic [8:0] exp_clr(input logic [3:0] a);
    logic [8:0] m = '0;
    for (int i = 0; i < NE; i++) if (a < 3 && (i / 4) == int'(a)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [15:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd0: return {12'd0, m_flag[3:0]};
      4'd1: return {12'd0, m_flag[7:4]};
      4'd2: return {15'd0, m_flag[8]};
      4'd3: return {7'd0, evt_level};
      4'd4: return {6'd0, m_mask[0], m_mode[0]};
      4'd5: return {6'd0, m_mask[1], m_mode[1]};
      4'd8, 4'd9, 4'd10, 4'd11: return {14'd0, m_psel[a - 4'd8]};
      default: return 16'd0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [3:0] a);
    if (a < 3) return "R2";
    if (a == 3) return "R4";
    if (a == 4 || a == 5) return "R5";
    if (a >= 8 && a <= 11) return "R9";
    return "R10";
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_flag = '0;
    for (int k = 0; k < 2; k++) begin
      m_mode[k] = 1'b0; m_mask[k] = '0; m_pcnt[k] = 0; m_tcnt[k] = 0;
    end
    for (int p = 0; p < 4; p++) m_psel[p] = '0;
  endtask

  task automatic model_edge();
    logic [8:0] clr;
    clr = reg_rd ? exp_clr(reg_addr) : '0;
    for (int k = 0; k < 2; k++) begin
      logic act, trg;
      act = |(m_flag & m_mask[k]);
      trg = |(evt_strobe & m_mask[k]);
      if (!m_mode[k]) begin
        m_tcnt[k] = 0;
        if (trg) m_pcnt[k] = PL;
        else if (m_pcnt[k] != 0) m_pcnt[k] = m_pcnt[k] - 1;
      end else begin
        m_pcnt[k] = 0;
        m_tcnt[k] = act ? ((m_tcnt[k] == T_HI + T_LO - 1) ? 0 : m_tcnt[k] + 1) : 0;
      end
    end
    m_flag = (m_flag & ~clr) | evt_strobe;
    if (reg_wr) begin
      if (reg_addr == 4'd4) {m_mask[0], m_mode[0]} = reg_wdata[9:0];
      if (reg_addr == 4'd5) {m_mask[1], m_mode[1]} = reg_wdata[9:0];
      if (reg_addr >= 4'd8 && reg_addr <= 4'd11) m_psel[reg_addr - 4'd8] = reg_wdata[1:0];
    end
  endtask

  // One cycle: check outputs, drive inputs, check read data, advance model.
  task automatic step(input logic [8:0] s, input logic rd, input logic wr,
                      input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    for (int k = 0; k < 2; k++)
      chk(dir_tag != "" ? dir_tag : (m_mode[k] ? "R7" : "R6"), 16'(irq_out[k]), 16'(exp_irq(k)));
    for (int p = 0; p < 4; p++) chk("R9", 16'(pin_out[p]), 16'(exp_pin(p)));
    evt_strobe = s; reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d;
    #1;
    chk(dir_tag != "" ? dir_tag : rd_tag(a), reg_rdata, exp_rd(a));
    @(posedge clk);
    model_edge();
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    step('0, 1'b0, 1'b1, a, d);
  endtask

  task automatic rd(input logic [3:0] a);
    step('0, 1'b1, 1'b0, a, '0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, 1'b0, 1'b0, 4'd7, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state of every register and output
    dir_tag = "R1";
    for (int a = 0; a < 16; a++) if (a != 3) rd(4'(a));
    dir_tag = "";

    // R4 live status follows levels without latching
    evt_level = 9'h15A; rd(4'd3);
    evt_level = 9'h0A5; rd(4'd3);
    evt_level = '0;

    // R6 one-shot with retrigger; disabled event ignored
    wr(4'd4, 16'h0004);            // event 1 enabled, one-shot
    wr(4'd8, 16'd1);               // pin0 <- irq0
    wr(4'd9, 16'd3);               // pin1 held low
    step(9'h002, 1'b0, 1'b0, 4'd7, '0);
    idle(2);
    step(9'h002, 1'b0, 1'b0, 4'd7, '0);
    step(9'h004, 1'b0, 1'b0, 4'd7, '0);  // event 2 not enabled
    idle(8);

    // R3 event coincident with clearing read survives
    dir_tag = "R3";
    step(9'h004, 1'b1, 1'b0, 4'd0, '0);
    rd(4'd0);
    rd(4'd0);
    dir_tag = "";

    // R7 train on event 8; stops after read of address 2
    wr(4'd5, 16'h0201);            // irq1 train, event 8
    wr(4'd10, 16'd2);              // pin2 <- irq1
    step(9'h100, 1'b0, 1'b0, 4'd7, '0);
    idle(40);
    rd(4'd2);
    idle(3);

    // R8 enable after flag set: train rises, one-shot stays low
    dir_tag = "R8";
    wr(4'd4, 16'h0001);            // irq0 train, nothing enabled
    wr(4'd5, 16'h0000);            // irq1 one-shot, nothing enabled
    step(9'h020, 1'b0, 1'b0, 4'd7, '0);
    idle(2);
    wr(4'd4, 16'h0041);            // enable event 5 on irq0
    wr(4'd5, 16'h0040);            // enable event 5 on irq1
    idle(3);
    rd(4'd1);
    idle(2);

    // R10 writes to flag, status and unused addresses change nothing
    dir_tag = "R10";
    step(9'h001, 1'b0, 1'b0, 4'd7, '0);
    wr(4'd0, 16'hFFFF);
    wr(4'd3, 16'hFFFF);
    wr(4'd6, 16'hFFFF);
    wr(4'd14, 16'hFFFF);
    rd(4'd6); rd(4'd12); rd(4'd15); rd(4'd0);
    dir_tag = "";

    // Random traffic
    for (int n = 0; n < 6000; n++) begin
      logic [8:0]  s;
      logic        r, w;
      logic [3:0]  a;
      logic [15:0] d;
      s = '0;
      for (int i = 0; i < NE; i++) if ($urandom_range(0, 39) == 0) s[i] = 1'b1;
      r = ($urandom_range(0, 9) == 0);
      w = !r && ($urandom_range(0, 59) == 0);
      a = 4'($urandom_range(0, 15));
      if (r && $urandom_range(0, 3) != 0) a = 4'($urandom_range(0, 2));
      if (w && $urandom_range(0, 1) == 0) a = 4'($urandom_range(4, 5));
      d = 16'($urandom);
      if ($urandom_range(0, 31) == 0) evt_level = 9'($urandom);
      step(s, r, w, a, d);
    end
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule